// File: doc/BRIEF.md
# Face-Stack Accumulator Processor

A compact sequential processor built around a 16-bit word. Every instruction word splits into a narrow 4-bit opcode (bits 15:12) and a wide 12-bit operand `x` (bits 11:0). All computation happens on the top entry of an internal hardware stack, called the face. Each instruction pairs the face with either the memory word at address `x` or the literal value of `x` itself.

The processor talks to a single-port synchronous memory. Instructions and data share that memory. Read data appears one cycle after the address is presented. A write is committed on the clock edge at the end of the cycle in which the write enable is high. After reset the core fetches from address 0.

It runs until it decodes a null instruction. At that point it raises its halt flag and stays idle until the next reset.

Top module: `facestack_cpu`

## Requirements
- R1: Opcodes are 0 null, 1 push, 2 pop, 3 write, 4 add, 5 subtract, 6 multiply, 7 jump, 8 skip-unless-less, 9 skip-unless-equal, 10 AND, 11 OR, 12 XOR, 13 NOR, 14 shift-left, 15 rotate-left. Instructions that read memory[x] (1, 4, 5, 6, 10–13) take three cycles: fetch, decode, operand. Every other instruction takes two cycles.
- R2: Push places memory[x] on the face. Pop stores the face to memory[x] and removes it from the stack. Write stores the face to memory[x] and leaves the stack unchanged.
- R3: Add and subtract replace the face with face+memory[x] and face−memory[x], both wrapping modulo 2^16. Multiply replaces the face with the low 16 bits of face×memory[x].
- R4: AND, OR, XOR and NOR replace the face with the bitwise result of the face and memory[x].
- R5: Jump makes x the address of the next instruction fetched.
- R6: Skip-unless-less executes the next instruction when face < x and skips it otherwise. The comparison is unsigned, with x zero-extended.
- R7: Skip-unless-equal executes the next instruction when face == x and skips it otherwise.
- R8: Shift-left moves the face left by x positions with zero fill. Any count of 16 or more gives 0.
- R9: Rotate-left moves the face left circularly by x modulo 16 positions.
- R10: The stack holds 16 entries. Pushing onto a full stack discards the deepest entry. Popping an empty stack stores 0.
- R11: Opcode 0, whatever its operand, stops the processor and raises `halted`. From then on no memory write occurs until reset.
- R12: While reset is high, and in the first cycle after it, `halted` and `mem_we` are low and `mem_addr` is 0. The stack starts empty, so its face reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| halted | output | 1 | High once a null instruction has been decoded |
| mem_addr | output | 12 | Memory address for instruction fetch, operand read or store |
| mem_wdata | output | 16 | Store data; always the current face |
| mem_rdata | input | 16 | Memory read data, valid one cycle after its address |
| mem_we | output | 1 | Memory write enable |

## Verification
The bound checker watches several properties on every clock edge:
- halt is sticky, and no store happens while halted;
- stores are never back to back;
- the address fetched after a jump matches its operand;
- a pop exposes the entry that was beneath the face;
- a matching skip-unless-equal falls through to the next word;
- the state after reset is clean.

Other behaviours only show up as final memory contents, so the bench's programs have to exercise them:
- arithmetic wrap and product truncation;
- the four logic results;
- the shift and rotate count boundaries (0, 15, 16, 17 and beyond);
- unsigned comparison;
- stack overflow and underflow.

For these, a behavioural instruction-level model predicts every store, the cycle on which halt rises, and the final memory image.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_NULL  = 4'd0,
        OP_PUSH  = 4'd1,
        OP_POP   = 4'd2,
        OP_WRITE = 4'd3,
        OP_ADD   = 4'd4,
        OP_SUB   = 4'd5,
        OP_MUL   = 4'd6,
        OP_JUMP  = 4'd7,
        OP_SKLT  = 4'd8,
        OP_SKEQ  = 4'd9,
        OP_AND   = 4'd10,
        OP_OR    = 4'd11,
        OP_XOR   = 4'd12,
        OP_NOR   = 4'd13,
        OP_SHL   = 4'd14,
        OP_ROL   = 4'd15
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_HALT
    } state_e;

    typedef enum logic [1:0] {
        STK_HOLD,
        STK_PUSH,
        STK_POP,
        STK_LOAD
    } stk_cmd_e;

endpackage

// File: rtl/fsc_alu.sv
module fsc_alu
    import fsc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 12
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] face,
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] result
);
    // Rotation uses the low bits of the count (DATA_W is a power of two).
    localparam int ROT_W = $clog2(DATA_W);

    logic [2*DATA_W-1:0] product;
    logic [2*DATA_W-1:0] doubled;
    logic [ROT_W-1:0]    rot_amt;

    always_comb begin
        product = {{DATA_W{1'b0}}, face} * {{DATA_W{1'b0}}, operand};
        rot_amt = count[ROT_W-1:0];
        doubled = {face, face} << rot_amt;
        case (op)
            OP_ADD:  result = face + operand;
            OP_SUB:  result = face - operand;
            OP_MUL:  result = product[DATA_W-1:0];
            OP_AND:  result = face & operand;
            OP_OR:   result = face | operand;
            OP_XOR:  result = face ^ operand;
            OP_NOR:  result = ~(face | operand);
            OP_SHL:  result = (count >= CNT_W'(DATA_W)) ? '0 : (face << count);
            OP_ROL:  result = doubled[2*DATA_W-1:DATA_W];
            default: result = face;
        endcase
    end

endmodule

// File: rtl/fsc_stack.sv
module fsc_stack
    import fsc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  stk_cmd_e          cmd,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] face,
    output logic [DATA_W-1:0] second
);
    logic [DATA_W-1:0] ent_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        if (i == 0) begin : g_top
            always_ff @(posedge clk) begin
                if (rst) ent_q[i] <= '0;
                else begin
                    case (cmd)
                        STK_PUSH, STK_LOAD: ent_q[i] <= din;
                        STK_POP:            ent_q[i] <= ent_q[i+1];
                        default:            ent_q[i] <= ent_q[i];
                    endcase
                end
            end
        end else if (i == DEPTH-1) begin : g_bottom
            always_ff @(posedge clk) begin
                if (rst) ent_q[i] <= '0;
                else begin
                    case (cmd)
                        STK_PUSH: ent_q[i] <= ent_q[i-1];
                        STK_POP:  ent_q[i] <= '0;
                        default:  ent_q[i] <= ent_q[i];
                    endcase
                end
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (rst) ent_q[i] <= '0;
                else begin
                    case (cmd)
                        STK_PUSH: ent_q[i] <= ent_q[i-1];
                        STK_POP:  ent_q[i] <= ent_q[i+1];
                        default:  ent_q[i] <= ent_q[i];
                    endcase
                end
            end
        end
    end

    assign face   = ent_q[0];
    assign second = ent_q[1];

endmodule

// File: rtl/facestack_cpu.sv
module facestack_cpu
    import fsc_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int STACK_DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    output logic                      halted,
    output logic [DATA_W-OPC_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic                      mem_we
);
    localparam int X_W = DATA_W - OPC_W;

    state_e            state_q, state_d;
    logic [X_W-1:0]    pc_q, pc_d;
    opcode_e           ir_op_q;
    logic [X_W-1:0]    ir_x_q;
    opcode_e           cur_op;
    logic [X_W-1:0]    cur_x;
    logic              in_decode;
    stk_cmd_e          stk_cmd;
    logic [DATA_W-1:0] stk_din;
    logic [DATA_W-1:0] face, second;
    logic [DATA_W-1:0] alu_res;
    logic [DATA_W-1:0] x_ext;

    assign in_decode = (state_q == ST_DECODE);
    assign cur_op    = in_decode ? opcode_e'(mem_rdata[DATA_W-1 -: OPC_W]) : ir_op_q;
    assign cur_x     = in_decode ? mem_rdata[X_W-1:0] : ir_x_q;
    assign x_ext     = DATA_W'(cur_x);
    assign halted    = (state_q == ST_HALT);
    assign mem_wdata = face;

    fsc_stack #(.DATA_W(DATA_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk    (clk),
        .rst    (rst),
        .cmd    (stk_cmd),
        .din    (stk_din),
        .face   (face),
        .second (second)
    );

    fsc_alu #(.DATA_W(DATA_W), .CNT_W(X_W)) u_alu (
        .op      (cur_op),
        .face    (face),
        .operand (mem_rdata),
        .count   (cur_x),
        .result  (alu_res)
    );

    always_comb begin
        state_d  = state_q;
        pc_d     = pc_q;
        mem_addr = pc_q;
        mem_we   = 1'b0;
        stk_cmd  = STK_HOLD;
        stk_din  = alu_res;
        case (state_q)
            ST_FETCH: state_d = ST_DECODE;
            ST_DECODE: begin
                state_d = ST_FETCH;
                pc_d    = pc_q + X_W'(1);
                case (cur_op)
                    OP_NULL: begin
                        state_d = ST_HALT;
                        pc_d    = pc_q;
                    end
                    OP_POP: begin
                        mem_addr = cur_x;
                        mem_we   = 1'b1;
                        stk_cmd  = STK_POP;
                    end
                    OP_WRITE: begin
                        mem_addr = cur_x;
                        mem_we   = 1'b1;
                    end
                    OP_JUMP: pc_d = cur_x;
                    OP_SKLT: if (!(face < x_ext)) pc_d = pc_q + X_W'(2);
                    OP_SKEQ: if (face != x_ext) pc_d = pc_q + X_W'(2);
                    OP_SHL, OP_ROL: stk_cmd = STK_LOAD;
                    default: begin
                        mem_addr = cur_x;
                        state_d  = ST_EXEC;
                    end
                endcase
            end
            ST_EXEC: begin
                state_d = ST_FETCH;
                if (cur_op == OP_PUSH) begin
                    stk_cmd = STK_PUSH;
                    stk_din = mem_rdata;
                end else begin
                    stk_cmd = STK_LOAD;
                end
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            ir_op_q <= OP_NULL;
            ir_x_q  <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            if (in_decode) begin
                ir_op_q <= cur_op;
                ir_x_q  <= cur_x;
            end
        end
    end

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker
    import fsc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int X_W    = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              halted,
    input logic              mem_we,
    input logic [X_W-1:0]    mem_addr,
    input logic              in_decode,
    input opcode_e           cur_op,
    input logic [X_W-1:0]    cur_x,
    input logic [DATA_W-1:0] face,
    input logic [DATA_W-1:0] second,
    input logic [X_W-1:0]    pc
);
    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);

    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R2
    store_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R5
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (in_decode && cur_op == OP_JUMP) |=> (mem_addr == $past(cur_x)));

    // R10
    pop_expose_chk: assert property (@(posedge clk) disable iff (rst)
        (in_decode && cur_op == OP_POP) |=> (face == $past(second)));

    // R7
    skeq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (in_decode && cur_op == OP_SKEQ && face == DATA_W'(cur_x))
        |=> (mem_addr == $past(pc) + X_W'(1)));

    // R12
    reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_addr == '0 && !halted && !mem_we));

endmodule

bind facestack_cpu fsc_checker #(.DATA_W(DATA_W), .X_W(X_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .halted    (halted),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .in_decode (in_decode),
    .cur_op    (cur_op),
    .cur_x     (cur_x),
    .face      (face),
    .second    (second),
    .pc        (pc_q)
);

// File: tb/facestack_cpu_bench.sv
module facestack_cpu_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_N      = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halted;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_we;

    logic [15:0] mem     [MEM_N];
    logic [15:0] ref_mem [MEM_N];
    logic [15:0] stk [$];
    int          exp_wa [$];
    int          exp_wd [$];
    int          exp_cycles;
    int          n_tests = 0;
    int          n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    facestack_cpu u_facestack_cpu (
        .clk       (clk),
        .rst       (rst),
        .halted    (halted),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we)
    );

    always @(posedge clk) begin
        if (mem_we === 1'b1) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int op, input int x);
        return {op[3:0], x[11:0]};
    endfunction

    task automatic put(input int a, input logic [15:0] w);
        mem[a]     = w;
        ref_mem[a] = w;
    endtask

    task automatic clear_all();
        for (int a = 0; a < MEM_N; a++) begin
            mem[a]     = '0;
            ref_mem[a] = '0;
        end
    endtask

    function automatic logic [15:0] top_of();
        return (stk.size() != 0) ? stk[0] : 16'h0;
    endfunction

    function automatic void set_top(input logic [15:0] v);
        if (stk.size() == 0) stk.push_front(v);
        else stk[0] = v;
    endfunction

    // Instruction-level behavioural model of the requirements
    task automatic run_model();
        int pc = 0;
        bit done = 0;
        exp_cycles = 0;
        stk.delete();
        exp_wa.delete();
        exp_wd.delete();
        for (int step = 0; step < 5000 && !done; step++) begin
            logic [15:0] w  = ref_mem[pc];
            int          op = int'(w[15:12]);
            int          x  = int'(w[11:0]);
            logic [15:0] f  = top_of();
            logic [15:0] m  = ref_mem[x];
            logic [31:0] p;
            int          r;
            int          npc = (pc + 1) % 4096;
            case (op)
                0: begin exp_cycles += 2; done = 1; end
                1: begin
                    stk.push_front(m);
                    if (stk.size() > 16) void'(stk.pop_back());
                    exp_cycles += 3;
                end
                2, 3: begin
                    exp_wa.push_back(x);
                    exp_wd.push_back(int'(f));
                    ref_mem[x] = f;
                    if (op == 2 && stk.size() != 0) void'(stk.pop_front());
                    exp_cycles += 2;
                end
                7: begin npc = x; exp_cycles += 2; end
                8: begin if (!(int'(f) < x)) npc = (pc + 2) % 4096; exp_cycles += 2; end
                9: begin if (int'(f) != x) npc = (pc + 2) % 4096; exp_cycles += 2; end
                14: begin set_top((x >= 16) ? 16'h0 : 16'(f << x)); exp_cycles += 2; end
                15: begin
                    r = x % 16;
                    set_top(16'((f << r) | (f >> (16 - r))));
                    exp_cycles += 2;
                end
                default: begin
                    p = 32'(f) * 32'(m);
                    case (op)
                        4:  set_top(f + m);
                        5:  set_top(f - m);
                        6:  set_top(p[15:0]);
                        10: set_top(f & m);
                        11: set_top(f | m);
                        12: set_top(f ^ m);
                        default: set_top(~(f | m));
                    endcase
                    exp_cycles += 3;
                end
            endcase
            if (!done) pc = npc;
        end
    endtask

    task automatic run_dut(input string tag);
        int first_bad;
        run_model();
        rst = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(halted == 1'b0 && mem_we == 1'b0 && mem_addr == 12'h0, "R12",
              "reset outputs", {halted, mem_we, mem_addr}, 0);
        rst = 1'b0;
        for (int n = 1; n <= exp_cycles + 4; n++) begin
            @(negedge clk);
            if (mem_we === 1'b1) begin
                if (exp_wa.size() == 0) begin
                    check(1'b0, tag, "unexpected store", int'(mem_addr), -1);
                end else begin
                    check(int'(mem_addr) == exp_wa[0] && int'(mem_wdata) == exp_wd[0],
                          tag, "store addr/data",
                          {mem_addr, mem_wdata}, (exp_wa[0] << 16) | exp_wd[0]);
                    void'(exp_wa.pop_front());
                    void'(exp_wd.pop_front());
                end
            end
            // R1 cycle timing and R11 halt flag, compared every clock
            check(halted === (n >= exp_cycles), "R1/R11", "halted per cycle",
                  int'(halted), int'(n >= exp_cycles));
        end
        check(exp_wa.size() == 0, tag, "stores outstanding", exp_wa.size(), 0);
        first_bad = -1;
        for (int a = MEM_N - 1; a >= 0; a--)
            if (mem[a] !== ref_mem[a]) first_bad = a;
        check(first_bad < 0, tag, "memory image first bad addr", first_bad, -1);
        rst = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual %0d cycles expected completion", 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);

        // R3 arithmetic, R2 write then pop
        clear_all();
        put(0, mk(1, 'h100)); put(1, mk(4, 'h101)); put(2, mk(3, 'h200));
        put(3, mk(5, 'h102)); put(4, mk(2, 'h201)); put(5, mk(1, 'h101));
        put(6, mk(6, 'h103)); put(7, mk(2, 'h202)); put(8, mk(1, 'h104));
        put(9, mk(6, 'h105)); put(10, mk(2, 'h203)); put(11, mk(0, 0));
        put('h100, 16'h1234); put('h101, 16'hF000); put('h102, 16'h0300);
        put('h103, 16'h0010); put('h104, 16'h0123); put('h105, 16'h0456);
        run_dut("R3");

        // R4 logic
        clear_all();
        for (int k = 0; k < 4; k++) begin
            put(3*k,     mk(1, 'h100));
            put(3*k + 1, mk(10 + k, 'h101));
            put(3*k + 2, mk(2, 'h200 + k));
        end
        put(12, mk(0, 0));
        put('h100, 16'hA5C3); put('h101, 16'h0FF0);
        run_dut("R4");

        // R8 shift and R9 rotate boundaries
        clear_all();
        begin
            int cnt [10] = '{0, 4, 15, 16, 100, 4, 15, 16, 17, 0};
            for (int k = 0; k < 10; k++) begin
                put(3*k,     mk(1, 'h100));
                put(3*k + 1, mk((k < 5) ? 14 : 15, cnt[k]));
                put(3*k + 2, mk(2, 'h200 + k));
            end
            put(30, mk(0, 0));
        end
        put('h100, 16'h8E31);
        run_dut("R8/R9");

        // R5 jump, R6 unsigned less, R7 equal
        clear_all();
        put(0, mk(1, 'h100)); put(1, mk(4, 'h101)); put(2, mk(3, 'h180));
        put(3, mk(8, 5));     put(4, mk(7, 1));     put(5, mk(9, 5));
        put(6, mk(2, 'h181)); put(7, mk(1, 'h102)); put(8, mk(9, 3));
        put(9, mk(3, 'h182)); put(10, mk(8, 3));    put(11, mk(3, 'h183));
        put(12, mk(1, 'h103)); put(13, mk(8, 'hFFF)); put(14, mk(3, 'h184));
        put(15, mk(9, 0));    put(16, mk(3, 'h185)); put(17, mk(1, 'h104));
        put(18, mk(8, 6));    put(19, mk(3, 'h186)); put(20, mk(7, 22));
        put(21, mk(3, 'h187)); put(22, mk(0, 0));
        put('h100, 16'h0000); put('h101, 16'h0001); put('h102, 16'h0007);
        put('h103, 16'h8000); put('h104, 16'h0005);
        run_dut("R5/R6/R7");

        // R10 overflow drops deepest, underflow gives zero
        clear_all();
        for (int k = 0; k < 18; k++) begin
            put(k, mk(1, 'h100 + k));
            put(18 + k, mk(2, 'h200 + k));
            put('h100 + k, 16'h1000 + 16'(k));
        end
        put(36, mk(2, 'h220)); put(37, mk(0, 0));
        run_dut("R10");

        // R11 null with nonzero operand halts before the following store
        clear_all();
        put(0, mk(0, 'hABC)); put(1, mk(2, 'h200));
        run_dut("R11");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule